// File: doc/BRIEF.md
# Iterative Integer Multiplier

This block computes integer products for a 64-bit processor pipeline over several cycles. A request carries two 64-bit operands, a 3-bit operation code and a word flag. The block forms the full product of the operands, each read as signed or unsigned according to the code, and returns either the lower or the upper 64 bits. In word mode only the low 32 bits of each operand take part, both read as signed. The low 32 bits of that product are sign-extended to 64 bits.

Each operand is widened by one bit, with a sign or zero fill chosen per operand, so that one signed shift-add engine covers every signedness mix. The engine retires one multiplier bit per cycle: 64 steps for full width, 32 in word mode, then one cycle that selects the result. A request is accepted with `start_i` while `busy_o` is low. `done_o` pulses once when `result_o` becomes valid, and the result then holds until the next operation completes.

Top module: `imul_unit`

## Requirements
- R1: With op_i = 3'b000 and word_i = 0, result_o is bits 63..0 of the product. This value does not depend on how the operands are signed.
- R2: With op_i = 3'b001 and word_i = 0, result_o is bits 127..64 of the product of a_i and b_i, both read as signed.
- R3: With op_i = 3'b010 and word_i = 0, result_o is bits 127..64 of the product of a_i read as signed and b_i read as unsigned.
- R4: With op_i = 3'b011 and word_i = 0, result_o is bits 127..64 of the product of a_i and b_i, both read as unsigned.
- R5: With word_i = 1, result_o is bits 31..0 of the signed product of a_i[31:0] and b_i[31:0], sign-extended from bit 31. op_i and operand bits 63..32 have no effect.
- R6: A start_i is accepted only in a cycle where busy_o is low. busy_o rises in the cycle after acceptance, and a start_i raised while busy_o is high is ignored.
- R7: done_o is high for exactly one cycle per accepted request, and busy_o is low while done_o is high. result_o changes only in the cycle where done_o rises and otherwise holds its value.
- R8: done_o rises 65 clock edges after the accepting edge in full-width mode and 33 edges after it in word mode.
- R9: While rst_ni is low, busy_o and done_o are low and result_o is zero.
- R10: Op codes 3'b100 to 3'b111 with word_i = 0 return the low 64 bits, the same as op_i = 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken while busy_o is low |
| op_i | input | 3 | Operation code: signedness and half select |
| word_i | input | 1 | Word mode: 32-bit signed product, sign-extended |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| result_o | output | 64 | Selected product half, held between operations |

## Verification
The checker watches the handshake on every cycle. It confirms that an accepted start raises busy, that done is a single-cycle pulse never seen together with busy, and that the result moves only on a done cycle. A cycle counter confirms the 65-edge and 33-edge latencies for each mode. The arithmetic is shown only by the bench's scenarios. They cover each signedness and half choice, word mode with junk in the upper operand bits and an ignored op code, reserved op codes, the extreme operand values, and a start raised while busy that must leave no trace.

// File: rtl/imul_pkg.sv
package imul_pkg;
  typedef enum logic [2:0] {
    OP_LO    = 3'b000,
    OP_HI_SS = 3'b001,
    OP_HI_SU = 3'b010,
    OP_HI_UU = 3'b011
  } imul_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SEL  = 2'd2
  } imul_state_e;
endpackage

// File: rtl/imul_operand.sv
// Widen one operand by a fill bit so a single signed engine serves all modes.
module imul_operand #(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         signed_i,
  input  logic         word_i,
  output logic [W:0]   ext_o
);
  always_comb begin
    if (word_i) ext_o = {{(W-HW+1){val_i[HW-1]}}, val_i[HW-1:0]};
    else        ext_o = {signed_i & val_i[W-1], val_i};
  end
endmodule

// File: rtl/imul_ctrl.sv
module imul_ctrl
  import imul_pkg::*;
#(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic word_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(W);

  imul_state_e   st_q;
  logic [CW-1:0] cnt_q, last_q;
  logic          done_q;

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign step_o = (st_q == ST_RUN);
  assign fin_o  = (st_q == ST_SEL);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      last_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_o;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_RUN;
          cnt_q  <= '0;
          last_q <= word_i ? CW'(HW-1) : CW'(W-1);
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == last_q) st_q <= ST_SEL;
        end
        ST_SEL:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/imul_datapath.sv
// Radix-2 shift-add on (W+1)-bit signed operands. The sign weight of the
// multiplier is preloaded as a negative term so every step is a plain add.
module imul_datapath #(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic           word_i,
  input  logic [W:0]     x_i,
  input  logic [W:0]     y_i,
  output logic [2*W-1:0] prod_o
);
  localparam int AW = 2*W + 2;

  logic [AW-1:0] acc_q, mcand_q, x_sx;
  logic [W-1:0]  mplier_q;

  assign x_sx   = {{(AW-W-1){x_i[W]}}, x_i};
  assign prod_o = acc_q[2*W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (load_i) begin
      mcand_q  <= x_sx;
      mplier_q <= y_i[W-1:0];
      if (y_i[W]) acc_q <= '0 - (word_i ? (x_sx << HW) : (x_sx << W));
      else        acc_q <= '0;
    end else if (step_i) begin
      if (mplier_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end
endmodule

// File: rtl/imul_result.sv
module imul_result
  import imul_pkg::*;
#(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           fin_i,
  input  logic [2:0]     op_i,
  input  logic           word_i,
  input  logic [2*W-1:0] prod_i,
  output logic [W-1:0]   res_o
);
  logic hi_q, word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= 1'b0;
      word_q <= 1'b0;
      res_o  <= '0;
    end else begin
      if (load_i) begin
        hi_q   <= (op_i == OP_HI_SS) || (op_i == OP_HI_SU) || (op_i == OP_HI_UU);
        word_q <= word_i;
      end
      if (fin_i) begin
        if (word_q)    res_o <= {{(W-HW){prod_i[HW-1]}}, prod_i[HW-1:0]};
        else if (hi_q) res_o <= prod_i[2*W-1:W];
        else           res_o <= prod_i[W-1:0];
      end
    end
  end
endmodule

// File: rtl/imul_unit.sv
module imul_unit
  import imul_pkg::*;
#(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic         word_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  logic           a_signed, b_signed;
  logic [W:0]     a_ext, b_ext;
  logic           load, step, fin;
  logic [2*W-1:0] prod;

  // low-half and reserved codes use zero fill; the low half is identical
  assign a_signed = (op_i == OP_HI_SS) || (op_i == OP_HI_SU);
  assign b_signed = (op_i == OP_HI_SS);

  imul_operand #(.W(W), .HW(HW)) opa_i (
    .val_i(a_i), .signed_i(a_signed), .word_i(word_i), .ext_o(a_ext));

  imul_operand #(.W(W), .HW(HW)) opb_i (
    .val_i(b_i), .signed_i(b_signed), .word_i(word_i), .ext_o(b_ext));

  imul_ctrl #(.W(W), .HW(HW)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .word_i(word_i),
    .load_o(load), .step_o(step), .fin_o(fin), .busy_o(busy_o), .done_o(done_o));

  imul_datapath #(.W(W), .HW(HW)) dp_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .word_i(word_i), .x_i(a_ext), .y_i(b_ext), .prod_o(prod));

  imul_result #(.W(W), .HW(HW)) res_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .fin_i(fin),
    .op_i(op_i), .word_i(word_i), .prod_i(prod), .res_o(result_o));
endmodule

// File: rtl/imul_chk.sv
module imul_chk #(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         word_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  localparam int LW = $clog2(W + 2) + 1;

  logic [LW-1:0] lat_q;
  logic          word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      word_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      lat_q  <= '0;
      word_q <= word_i;
    end else if (busy_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R6
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R7
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  // R8
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == (word_q ? LW'(HW + 1) : LW'(W + 1))));
endmodule

bind imul_unit imul_chk #(.W(W), .HW(HW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .word_i(word_i),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o));

// File: tb/imul_unit_tb_top.sv
module imul_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'b000;
  logic        word = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic        busy, done;
  logic [63:0] result;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic prev_done = 1'b0;

  logic [63:0] exp_q[$];
  int          lat_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  imul_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .word_i(word),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .result_o(result));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [2:0] o, input logic w,
                                        input logic [63:0] x, input logic [63:0] y);
    logic signed [129:0] px, py, p;
    logic sx, sy, hi;
    if (w) begin
      px = {{98{x[31]}}, x[31:0]};
      py = {{98{y[31]}}, y[31:0]};
      p  = px * py;
      return {{32{p[31]}}, p[31:0]};
    end
    sx = (o == 3'b001) || (o == 3'b010);
    sy = (o == 3'b001);
    hi = (o == 3'b001) || (o == 3'b010) || (o == 3'b011);
    px = {{66{sx & x[63]}}, x};
    py = {{66{sy & y[63]}}, y};
    p  = px * py;
    return hi ? p[127:64] : p[63:0];
  endfunction

  // monitor: pop and compare on each done
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected done", {63'd0, done}, 64'd0);
        end else begin
          automatic logic [63:0] e = exp_q.pop_front();
          automatic int          l = lat_q.pop_front();
          automatic string       t = tag_q.pop_front();
          check(result === e, t, result, e);
          check(cyc == l, "R8 latency", 64'(cyc), 64'(l));
          check(!busy, "R7 busy low at done", {63'd0, busy}, 64'd0);
        end
        if (prev_done) check(1'b0, "R7 done pulse width", 64'd1, 64'd0);
      end
      prev_done <= done;
    end
  end

  task automatic issue(input logic [2:0] o, input logic w, input logic [63:0] x,
                       input logic [63:0] y, input string tag);
    while (busy) @(posedge clk);
    @(posedge clk); #2;
    op = o; word = w; a = x; b = y; start = 1'b1;
    exp_q.push_back(model(o, w, x, y));
    lat_q.push_back(cyc + 1 + (w ? 33 : 65));
    tag_q.push_back(tag);
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9
    check(!busy && !done && result == 64'd0, "R9 reset state",
          {busy, done, 62'd0} | result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && result == 64'd0, "R9 after release",
          {busy, done, 62'd0} | result, 64'd0);

    issue(3'b000, 1'b0, 64'hFFFF_FFFF_FFFF_FFFD, 64'd7, "R1 low signed pattern");
    drain();
    issue(3'b000, 1'b0, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, "R1 low wrap");
    drain();
    issue(3'b001, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R2 -1*-1");
    drain();
    issue(3'b001, 1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R2 min*min");
    drain();
    issue(3'b001, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R2 max*min");
    drain();
    issue(3'b010, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R3 -1*umax");
    drain();
    issue(3'b010, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R3 min*umax");
    drain();
    issue(3'b011, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R4 umax*umax");
    drain();
    issue(3'b011, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R4 zero");
    drain();
    issue(3'b011, 1'b1, 64'hDEAD_BEEF_8000_0000, 64'hFFFF_0000_0000_0002, "R5 word min*2 op ignored");
    drain();
    issue(3'b001, 1'b1, 64'h1234_5678_7FFF_FFFF, 64'hABCD_0000_0000_0002, "R5 word overflow sext");
    drain();
    issue(3'b000, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, "R5 word -1*-1");
    drain();
    issue(3'b101, 1'b0, 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFF9, "R10 reserved op 101");
    drain();
    issue(3'b111, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R10 reserved op 111");
    drain();

    for (int i = 0; i < 16; i++) begin
      automatic logic [63:0] x = {$urandom(), $urandom()};
      automatic logic [63:0] y = {$urandom(), $urandom()};
      automatic logic [2:0]  o = 3'(i % 4);
      automatic logic        w = (i % 5 == 4);
      issue(o, w, x, y, w ? "R5 random" : (o == 3'd0 ? "R1 random" :
                        (o == 3'd1 ? "R2 random" : (o == 3'd2 ? "R3 random" : "R4 random"))));
      drain();
    end

    // R6: start while busy must leave no trace
    issue(3'b011, 1'b0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0005, "R6 first op kept");
    repeat (4) @(posedge clk);
    #2;
    op = 3'b001; word = 1'b1; a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h77; start = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    start = 1'b0;
    drain();
    repeat (10) @(negedge clk);
    check(!busy, "R6 no second op started", {63'd0, busy}, 64'd0);

    // R7: result holds after done while inputs move
    begin
      automatic logic [63:0] held = result;
      a = 64'h5555; b = 64'hAAAA; op = 3'b001;
      repeat (6) @(negedge clk);
      check(result === held && !done, "R7 result held", result, held);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule